// File: doc/BRIEF.md
# Bidirectional Panel Scan Driver

This block holds the digital addressing logic of a matrix display panel. A column token walks across groups of twelve adjacent columns. It is driven by two complementary horizontal phase clocks. A row token walks the gate lines once per line strobe. Each walker has its own direction input, so the picture can be mirrored left/right and up/down. The row output reaches the gate lines only while the gate enable input is high.

Three mode inputs shrink the active window by forcing a black border that stays centred on the panel. The full window is 1024 by 768. Dropping the horizontal mode input narrows it to 960 columns. Dropping the vertical mode input while the blank request is high shortens it to 640 rows. For every column of the selected group, a per-lane flag reports whether that pixel must be driven black. All phase, strobe and mode inputs are sampled on the system clock, and edges are found by comparing each input against its registered copy.

Top module: `panel_scan_top`

## Requirements
- R1: After reset no column group and no gate line is selected, and every lane of `pix_black` is 1.
- R2: A rising edge of `hclk_a` while `h_start` is high places the column token at group 0 when `h_dir`=1, or at group 85 when `h_dir`=0. Group g covers columns 12g to 12g+11, and lane k of `pix_black` is column 12g+k.
- R3: Every other edge of `hclk_a` or `hclk_b` moves the column token by one group: upward when `h_dir`=1, downward when `h_dir`=0. One full two-phase period therefore moves it two groups.
- R4: When the token steps past the last group in its direction, no group is selected until the next start.
- R5: A start while a token is in flight restarts the scan at the first group and leaves a single token.
- R6: A rising edge of `v_clk` with `v_start` high selects row 0 when `v_dir`=1, or row 767 when `v_dir`=0. Each later rising edge moves one row in that direction. After the end row, no row is selected.
- R7: `gate_sel` shows the selected row only while `gate_en` is 1 and is all zero otherwise. `gate_en` does not move the row token.
- R8: With all modes full (`hb_full`=1, and either `vb_full`=1 or `blank_req`=0), a lane is black only if its column is 1024 or more, or if no column group or no row is selected.
- R9: With `hb_full`=0, columns below 32 and columns from 992 upward are also black.
- R10: With `vb_full`=0 and `blank_req`=1, rows below 64 and rows from 704 upward are black. With `vb_full`=0 and `blank_req`=0, no row is blacked.
- R11: At most one column group and at most one gate line are selected at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| hclk_a | input | 1 | Horizontal phase clock, first phase |
| hclk_b | input | 1 | Horizontal phase clock, complementary phase |
| h_start | input | 1 | Column scan start, captured on hclk_a rise |
| h_dir | input | 1 | Column direction, 1 = ascending |
| v_clk | input | 1 | Line strobe, acts on rising edge |
| v_start | input | 1 | Row scan start, captured on v_clk rise |
| v_dir | input | 1 | Row direction, 1 = downward (ascending) |
| gate_en | input | 1 | Lets the selected row reach the gate lines |
| hb_full | input | 1 | 0 selects the 960-column window |
| vb_full | input | 1 | 0 (with blank_req) selects the 640-row window |
| blank_req | input | 1 | Blank request for the shortened row window |
| col_sel | output | 86 | One-hot column group select |
| gate_sel | output | 768 | One-hot gate line select |
| pix_black | output | 12 | Black-force flag per lane of the selected group |

## Verification
The hardest case to reach is a restart while a token is in flight. A start counts only on an `hclk_a` rise, but steps happen on every phase edge. The stimulus tracks the phase level, issues a neutral edge whenever the next edge would be a fall, and only then raises `h_start` again after a few steps. The border edges at columns 32 and 992 fall inside groups 2 and 82. The stimulus therefore sweeps the whole column range in each mode and compares every lane. The row crop is checked by a full walk of all 768 lines while a column group in the centre stays parked.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic {
        DIR_REV = 1'b0,
        DIR_FWD = 1'b1
    } scan_dir_e;

    typedef struct packed {
        logic ph_a;
        logic ph_b;
        logic line;
    } clk_hist_t;

endpackage

// File: rtl/scan_token.sv
module scan_token import scan_pkg::*; #(
    parameter int N = 86,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    input  logic         dir_i,
    output logic [W-1:0] idx_o,
    output logic         valid_o
);

    typedef struct packed {
        logic         valid;
        logic [W-1:0] idx;
    } tok_t;

    tok_t      tok_d, tok_q;
    scan_dir_e dir;
    logic      at_end;

    assign dir    = scan_dir_e'(dir_i);
    assign at_end = (dir == DIR_FWD) ? (tok_q.idx == W'(N - 1)) : (tok_q.idx == '0);

    always_comb begin
        tok_d = tok_q;
        if (load_i) begin
            tok_d.valid = 1'b1;
            tok_d.idx   = (dir == DIR_FWD) ? '0 : W'(N - 1);
        end else if (step_i && tok_q.valid) begin
            if (at_end) begin
                tok_d.valid = 1'b0;
            end else if (dir == DIR_FWD) begin
                tok_d.idx = tok_q.idx + W'(1);
            end else begin
                tok_d.idx = tok_q.idx - W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tok_q <= '0;
        end else begin
            tok_q <= tok_d;
        end
    end

    assign idx_o   = tok_q.idx;
    assign valid_o = tok_q.valid;

    // R2 / R6: a start lands on the first position of the chosen direction
    p_load_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && dir_i |=> valid_o && idx_o == '0);
    p_load_rev_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && !dir_i |=> valid_o && idx_o == W'(N - 1));
    p_step_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i && step_i && valid_o && dir_i && idx_o != W'(N - 1)
        |=> valid_o && idx_o == $past(idx_o) + W'(1));
    p_end_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i && step_i && valid_o && (dir_i ? idx_o == W'(N - 1) : idx_o == '0)
        |=> !valid_o);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i && !step_i |=> $stable(idx_o) && $stable(valid_o));
    p_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> idx_o <= W'(N - 1));

endmodule

// File: rtl/onehot_dec.sv
module onehot_dec #(
    parameter int N = 86,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [W-1:0] idx_i,
    input  logic         valid_i,
    output logic [N-1:0] hot_o
);

    for (genvar i = 0; i < N; i++) begin : g_dec
        assign hot_o[i] = valid_i && (idx_i == W'(i));
    end

endmodule

// File: rtl/border_mask.sv
module border_mask #(
    parameter int COLS     = 1024,
    parameter int ROWS     = 768,
    parameter int GROUP    = 12,
    parameter int H_MARGIN = 32,
    parameter int V_MARGIN = 64,
    parameter int GW       = 7,
    parameter int RW       = 10
) (
    input  logic [GW-1:0]    col_idx_i,
    input  logic             col_valid_i,
    input  logic [RW-1:0]    row_idx_i,
    input  logic             row_valid_i,
    input  logic             hb_full_i,
    input  logic             vb_full_i,
    input  logic             blank_req_i,
    output logic [GROUP-1:0] black_o
);

    logic [31:0] h_lo, h_hi, v_lo, v_hi, row_n, base_n;
    logic        row_black;

    always_comb begin
        h_lo   = hb_full_i ? 32'd0 : 32'(H_MARGIN);
        h_hi   = 32'(COLS) - h_lo;
        v_lo   = (!vb_full_i && blank_req_i) ? 32'(V_MARGIN) : 32'd0;
        v_hi   = 32'(ROWS) - v_lo;
        row_n  = 32'(row_idx_i);
        base_n = 32'(col_idx_i) * 32'(GROUP);
        row_black = !row_valid_i || (row_n < v_lo) || (row_n >= v_hi);
    end

    for (genvar k = 0; k < GROUP; k++) begin : g_lane
        logic [31:0] col_n;
        assign col_n = base_n + 32'(k);
        assign black_o[k] = row_black || !col_valid_i ||
                            (col_n < h_lo) || (col_n >= h_hi);
    end

endmodule

// File: rtl/panel_scan_top.sv
module panel_scan_top import scan_pkg::*; #(
    parameter int COLS     = 1024,
    parameter int ROWS     = 768,
    parameter int GROUP    = 12,
    parameter int H_MARGIN = 32,
    parameter int V_MARGIN = 64,
    localparam int NGRP    = (COLS + GROUP - 1) / GROUP,
    localparam int GW      = (NGRP > 1) ? $clog2(NGRP) : 1,
    localparam int RW      = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hclk_a,
    input  logic             hclk_b,
    input  logic             h_start,
    input  logic             h_dir,
    input  logic             v_clk,
    input  logic             v_start,
    input  logic             v_dir,
    input  logic             gate_en,
    input  logic             hb_full,
    input  logic             vb_full,
    input  logic             blank_req,
    output logic [NGRP-1:0]  col_sel,
    output logic [ROWS-1:0]  gate_sel,
    output logic [GROUP-1:0] pix_black
);

    clk_hist_t hist_d, hist_q;
    logic      h_load, h_step, v_load, v_step, a_rise, v_rise;
    logic [GW-1:0] col_idx;
    logic [RW-1:0] row_idx;
    logic          col_valid, row_valid;
    logic [ROWS-1:0] row_hot;

    always_comb begin
        hist_d.ph_a = hclk_a;
        hist_d.ph_b = hclk_b;
        hist_d.line = v_clk;
        a_rise = hclk_a && !hist_q.ph_a;
        v_rise = v_clk && !hist_q.line;
        h_load = a_rise && h_start;
        h_step = ((hclk_a ^ hist_q.ph_a) || (hclk_b ^ hist_q.ph_b)) && !h_load;
        v_load = v_rise && v_start;
        v_step = v_rise && !v_start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    scan_token #(.N(NGRP)) u_col_tok (
        .clk(clk), .rst_n(rst_n), .load_i(h_load), .step_i(h_step),
        .dir_i(h_dir), .idx_o(col_idx), .valid_o(col_valid)
    );

    scan_token #(.N(ROWS)) u_row_tok (
        .clk(clk), .rst_n(rst_n), .load_i(v_load), .step_i(v_step),
        .dir_i(v_dir), .idx_o(row_idx), .valid_o(row_valid)
    );

    onehot_dec #(.N(NGRP)) u_col_dec (
        .idx_i(col_idx), .valid_i(col_valid), .hot_o(col_sel)
    );

    onehot_dec #(.N(ROWS)) u_row_dec (
        .idx_i(row_idx), .valid_i(row_valid), .hot_o(row_hot)
    );

    assign gate_sel = row_hot & {ROWS{gate_en}};

    border_mask #(
        .COLS(COLS), .ROWS(ROWS), .GROUP(GROUP), .H_MARGIN(H_MARGIN),
        .V_MARGIN(V_MARGIN), .GW(GW), .RW(RW)
    ) u_mask (
        .col_idx_i(col_idx), .col_valid_i(col_valid), .row_idx_i(row_idx),
        .row_valid_i(row_valid), .hb_full_i(hb_full), .vb_full_i(vb_full),
        .blank_req_i(blank_req), .black_o(pix_black)
    );

    p_onehot_col_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_sel));
    p_onehot_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_sel));
    p_gate_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |-> gate_sel == '0);
    p_black_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        col_sel == '0 |-> &pix_black);
    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        h_load && h_dir |=> col_sel[0] && $countones(col_sel) == 1);

endmodule

// File: tb/panel_scan_top_tb_top.sv
`timescale 1ns/1ps
module panel_scan_top_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hclk_a = 1'b0, hclk_b = 1'b1, h_start = 1'b0, h_dir = 1'b1;
    logic v_clk = 1'b0, v_start = 1'b0, v_dir = 1'b1, gate_en = 1'b1;
    logic hb_full = 1'b1, vb_full = 1'b1, blank_req = 1'b0;
    logic [85:0]  col_sel;
    logic [767:0] gate_sel;
    logic [11:0]  pix_black;

    always #10 clk = ~clk;

    panel_scan_top dut_i (
        .clk(clk), .rst_n(rst_n), .hclk_a(hclk_a), .hclk_b(hclk_b),
        .h_start(h_start), .h_dir(h_dir), .v_clk(v_clk), .v_start(v_start),
        .v_dir(v_dir), .gate_en(gate_en), .hb_full(hb_full), .vb_full(vb_full),
        .blank_req(blank_req), .col_sel(col_sel), .gate_sel(gate_sel),
        .pix_black(pix_black)
    );

    typedef struct {
        string       tag;
        int          col;
        int          row;
        logic [11:0] blk;
    } exp_t;

    exp_t q[$];
    int compared = 0;
    int mismatched = 0;
    int m_col = -1;
    int m_row = -1;
    bit done = 0;

    function automatic logic [11:0] exp_black();
        logic [11:0] b;
        int hm = hb_full ? 0 : 32;
        int vm = (!vb_full && blank_req) ? 64 : 0;
        for (int k = 0; k < 12; k++) begin
            int c = m_col * 12 + k;
            b[k] = (m_col < 0) || (m_row < 0) || (c >= 1024) || (c < hm) ||
                   (c >= 1024 - hm) || (m_row < vm) || (m_row >= 768 - vm);
        end
        return b;
    endfunction

    task automatic push(input string tag);
        exp_t e;
        e.tag = tag;
        e.col = m_col;
        e.row = gate_en ? m_row : -1;
        e.blk = exp_black();
        q.push_back(e);
    endtask

    task automatic h_edge(input bit start, input string tag);
        @(negedge clk); #1;
        h_start = start;
        hclk_a  = ~hclk_a;
        hclk_b  = ~hclk_a;
        if (hclk_a && start) m_col = h_dir ? 0 : 85;
        else if (m_col >= 0) begin
            if (h_dir) m_col = (m_col == 85) ? -1 : m_col + 1;
            else       m_col = m_col - 1;
        end
        @(posedge clk); #1;
        push(tag);
        h_start = 1'b0;
    endtask

    task automatic h_begin(input string tag);
        if (hclk_a) h_edge(1'b0, tag);
        h_edge(1'b1, tag);
    endtask

    task automatic v_line(input bit start, input string tag);
        @(negedge clk); #1;
        v_clk = 1'b1; v_start = start;
        if (start) m_row = v_dir ? 0 : 767;
        else if (m_row >= 0) begin
            if (v_dir) m_row = (m_row == 767) ? -1 : m_row + 1;
            else       m_row = m_row - 1;
        end
        @(posedge clk); #1;
        push(tag);
        @(negedge clk); #1;
        v_clk = 1'b0; v_start = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic set_ctl(input bit g, input bit hf, input bit vf, input bit br,
                           input string tag);
        @(negedge clk); #1;
        gate_en = g; hb_full = hf; vb_full = vf; blank_req = br;
        @(posedge clk); #1;
        push(tag);
    endtask

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                int ac, ar;
                e = q.pop_front();
                ac = -1; ar = -1;
                for (int i = 0; i < 86; i++) if (col_sel[i]) ac = i;
                for (int i = 0; i < 768; i++) if (gate_sel[i]) ar = i;
                if ($countones(col_sel) > 1) ac = -2;
                if ($countones(gate_sel) > 1) ar = -2;
                compared += 3;
                if (ac != e.col) begin
                    mismatched++;
                    $display("FAIL %s (R11 if -2) column group: actual %0d expected %0d",
                             e.tag, ac, e.col);
                end
                if (ar != e.row) begin
                    mismatched++;
                    $display("FAIL %s (R11 if -2) gate line: actual %0d expected %0d",
                             e.tag, ar, e.row);
                end
                if (pix_black !== e.blk) begin
                    mismatched++;
                    $display("FAIL %s black lanes: actual %b expected %b",
                             e.tag, pix_black, e.blk);
                end
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        push("R1");

        // R6: row scan start, then column sweep in full mode (R2, R3, R4, R8)
        v_line(1'b1, "R6");
        h_begin("R2");
        for (int i = 0; i < 90; i++) h_edge(1'b0, (m_col == 85) ? "R4" : "R3/R8");

        // R9: narrowed window, full sweep
        set_ctl(1'b1, 1'b0, 1'b1, 1'b0, "R9");
        h_begin("R9");
        for (int i = 0; i < 88; i++) h_edge(1'b0, "R9");
        set_ctl(1'b1, 1'b1, 1'b1, 1'b0, "R8");

        // reverse column scan
        @(negedge clk); h_dir = 1'b0;
        h_begin("R2");
        for (int i = 0; i < 88; i++) h_edge(1'b0, (m_col == 0) ? "R4" : "R3");

        // R5: restart while in flight
        @(negedge clk); h_dir = 1'b1;
        h_begin("R5");
        for (int i = 0; i < 5; i++) h_edge(1'b0, "R5");
        h_begin("R5");
        h_edge(1'b0, "R11");
        h_edge(1'b0, "R5");

        // park the column token at group 40
        h_begin("R3");
        for (int i = 0; i < 40; i++) h_edge(1'b0, "R3");

        // R10: cropped rows, full walk
        set_ctl(1'b1, 1'b1, 1'b0, 1'b1, "R10");
        v_line(1'b1, "R10");
        for (int i = 0; i < 768; i++) v_line(1'b0, (m_row == 767) ? "R6" : "R10");
        v_line(1'b1, "R10");
        for (int i = 0; i < 70; i++) v_line(1'b0, "R10");
        set_ctl(1'b1, 1'b1, 1'b0, 1'b0, "R10");
        set_ctl(1'b1, 1'b1, 1'b1, 1'b0, "R8");

        // R7: gate enable masks output only
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0, "R7");
        repeat (4) begin @(posedge clk); #1; push("R7"); end
        set_ctl(1'b1, 1'b1, 1'b1, 1'b0, "R7");

        // R6: upward row scan
        @(negedge clk); v_dir = 1'b0;
        v_line(1'b1, "R6");
        v_line(1'b0, "R6");
        v_line(1'b0, "R6");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule